// File: doc/BRIEF.md
# Microcoded Accumulator Machine Control Unit

This block is the control unit and datapath of a small accumulator machine. A fixed 128-word microprogram store sequences every step. Each 20-bit microword holds three separately decoded three-bit operation fields, a condition select, a branch kind and a seven-bit target. The three fields work in parallel, and each drives its own group of register transfers. The datapath holds a 16-bit accumulator and a 16-bit data register, plus an 11-bit program counter and an 11-bit address register.

The block connects to an external word memory through an address port, a write-data port, a write strobe and a read-data port. The read-data port is combinational. After reset the sequencer runs a fetch routine. That routine dispatches on the opcode of the fetched word into one of four execute routines (add, conditional branch, store, exchange). An indirect-address subroutine resolves a pointer when the instruction requests one. Every routine returns to fetch.

Top module: `ucpu_core`

## Requirements
- R1: While reset is held (active low, asynchronous), `mem_we` is 0 and `mem_addr` is 0, because the address register clears. The accumulator, data register, program counter and return register also clear, and the sequencer points at the fetch routine at microaddress 64.
- R2: An instruction word has the indirect flag in bit 15, the opcode in bits 14:11 and the address in bits 10:0. The fetch routine first copies PC into AR. Next it loads DR from memory and increments PC. Then it loads AR from DR[10:0] and jumps to microaddress {0, opcode, 00}.
- R3: Opcode 0000 adds the memory word at the effective address into the accumulator, modulo 2^16.
- R4: Opcode 0010 writes the accumulator to memory at the effective address in a single write cycle.
- R5: Opcode 0011 swaps the accumulator with the memory word at the effective address. Both transfers of the swap step use the register values from before that step.
- R6: Opcode 0001 loads PC with the effective address when accumulator bit 15 is 1. When that bit is 0, execution falls through to the next instruction with no memory write.
- R7: When bit 15 of the instruction is 1, the effective address is bits 10:0 of the memory word at the instruction's address field. The subroutine at microaddress 67 resolves it and then returns to the step after its caller.
- R8: Opcodes 0100 to 1111 write nothing to memory and leave the accumulator unchanged. Execution continues with the next instruction.
- R9: `mem_we` is high only during memory-write steps of execute routines, one cycle per store or exchange, with `mem_addr` equal to AR and `mem_wdata` equal to DR.
- R10: The sequencer supports conditional jump to the target, conditional call that saves the current microaddress plus one, return to the saved address, and opcode dispatch. When the condition is false, the sequencer steps to the next microaddress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W (11) | Word address, driven from AR |
| mem_wdata | output | DATA_W (16) | Write data, driven from DR |
| mem_we | output | 1 | Write strobe, high during a write step |
| mem_rdata | input | DATA_W (16) | Combinational read data for `mem_addr` |

## Verification
The bench builds the block with its default widths: 16-bit data and an 11-bit address. With these widths the opcode sits in bits 14:11 and the indirect flag in bit 15, so the bench encodes instruction words from the field positions given in the requirements. The full 2048-word address space lets operands such as 0x8001 and 0xF000 exercise sign-driven branching and accumulator wraparound. Pointer words placed away from the program exercise the indirect path for add, exchange and a taken branch.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

    localparam int UADDR_W = 7;
    localparam int UOP_W   = 3;
    localparam int UOP_N   = 1 << UOP_W;
    localparam int OPC_W   = 4;

    localparam logic [UADDR_W-1:0] U1 = 1;
    localparam logic [UADDR_W-1:0] U2 = 2;
    localparam logic [UADDR_W-1:0] U3 = 3;

    // routine origins; the opcode dispatch fixes the first four
    localparam logic [UADDR_W-1:0] ORG_ADD   = 7'd0;
    localparam logic [UADDR_W-1:0] ORG_BRN   = 7'd4;
    localparam logic [UADDR_W-1:0] ORG_STO   = 7'd8;
    localparam logic [UADDR_W-1:0] ORG_EXC   = 7'd12;
    localparam logic [UADDR_W-1:0] ORG_FETCH = 7'd64;
    localparam logic [UADDR_W-1:0] ORG_INDIR = 7'd67;

    // first field
    localparam int F_NOP    = 0;
    localparam int F1_ADD   = 1;
    localparam int F1_CLR   = 2;
    localparam int F1_INC   = 3;
    localparam int F1_DRTAC = 4;
    localparam int F1_DRTAR = 5;
    localparam int F1_PCTAR = 6;
    localparam int F1_WRITE = 7;
    // second field
    localparam int F2_SUB   = 1;
    localparam int F2_OR    = 2;
    localparam int F2_AND   = 3;
    localparam int F2_READ  = 4;
    localparam int F2_ACTDR = 5;
    localparam int F2_INCDR = 6;
    localparam int F2_PCTDR = 7;
    // third field
    localparam int F3_XOR   = 1;
    localparam int F3_COM   = 2;
    localparam int F3_SHL   = 3;
    localparam int F3_SHR   = 4;
    localparam int F3_INCPC = 5;
    localparam int F3_ARTPC = 6;
    localparam int F3_RSVD  = 7;

    typedef enum logic [1:0] {
        COND_ONE  = 2'd0,
        COND_IND  = 2'd1,
        COND_SIGN = 2'd2,
        COND_ZERO = 2'd3
    } cond_e;

    typedef enum logic [1:0] {
        SEQ_JMP  = 2'd0,
        SEQ_CALL = 2'd1,
        SEQ_RET  = 2'd2,
        SEQ_MAP  = 2'd3
    } seq_e;

    typedef struct packed {
        logic [UOP_W-1:0]   f1;
        logic [UOP_W-1:0]   f2;
        logic [UOP_W-1:0]   f3;
        cond_e              cd;
        seq_e               br;
        logic [UADDR_W-1:0] ad;
    } uword_t;

    typedef struct packed {
        logic [UADDR_W-1:0] car;
        logic [UADDR_W-1:0] sbr;
    } seq_t;

    function automatic uword_t mk(input int f1, input int f2, input int f3,
                                  input cond_e cd, input seq_e br,
                                  input logic [UADDR_W-1:0] ad);
        uword_t w;
        w.f1 = UOP_W'(f1);
        w.f2 = UOP_W'(f2);
        w.f3 = UOP_W'(f3);
        w.cd = cd;
        w.br = br;
        w.ad = ad;
        return w;
    endfunction

endpackage

// File: rtl/ucpu_rom.sv
module ucpu_rom
    import ucpu_pkg::*;
(
    input  logic [UADDR_W-1:0] addr,
    output uword_t             word
);

    always_comb begin
        word = mk(F_NOP, F_NOP, F_NOP, COND_ONE, SEQ_JMP, ORG_FETCH);
        case (addr)
            ORG_ADD:        word = mk(F_NOP, F_NOP, F_NOP, COND_IND, SEQ_CALL, ORG_INDIR);
            ORG_ADD + U1:   word = mk(F_NOP, F2_READ, F_NOP, COND_ONE, SEQ_JMP, ORG_ADD + U2);
            ORG_ADD + U2:   word = mk(F1_ADD, F_NOP, F_NOP, COND_ONE, SEQ_JMP, ORG_FETCH);
            ORG_BRN:        word = mk(F_NOP, F_NOP, F_NOP, COND_SIGN, SEQ_JMP, ORG_BRN + U2);
            ORG_BRN + U2:   word = mk(F_NOP, F_NOP, F_NOP, COND_IND, SEQ_CALL, ORG_INDIR);
            ORG_BRN + U3:   word = mk(F_NOP, F_NOP, F3_ARTPC, COND_ONE, SEQ_JMP, ORG_FETCH);
            ORG_STO:        word = mk(F_NOP, F_NOP, F_NOP, COND_IND, SEQ_CALL, ORG_INDIR);
            ORG_STO + U1:   word = mk(F_NOP, F2_ACTDR, F_NOP, COND_ONE, SEQ_JMP, ORG_STO + U2);
            ORG_STO + U2:   word = mk(F1_WRITE, F_NOP, F_NOP, COND_ONE, SEQ_JMP, ORG_FETCH);
            ORG_EXC:        word = mk(F_NOP, F_NOP, F_NOP, COND_IND, SEQ_CALL, ORG_INDIR);
            ORG_EXC + U1:   word = mk(F_NOP, F2_READ, F_NOP, COND_ONE, SEQ_JMP, ORG_EXC + U2);
            ORG_EXC + U2:   word = mk(F1_DRTAC, F2_ACTDR, F_NOP, COND_ONE, SEQ_JMP, ORG_EXC + U3);
            ORG_EXC + U3:   word = mk(F1_WRITE, F_NOP, F_NOP, COND_ONE, SEQ_JMP, ORG_FETCH);
            ORG_FETCH:      word = mk(F1_PCTAR, F_NOP, F_NOP, COND_ONE, SEQ_JMP, ORG_FETCH + U1);
            ORG_FETCH + U1: word = mk(F_NOP, F2_READ, F3_INCPC, COND_ONE, SEQ_JMP, ORG_FETCH + U2);
            ORG_FETCH + U2: word = mk(F1_DRTAR, F_NOP, F_NOP, COND_ONE, SEQ_MAP, '0);
            ORG_INDIR:      word = mk(F_NOP, F2_READ, F_NOP, COND_ONE, SEQ_JMP, ORG_INDIR + U1);
            ORG_INDIR + U1: word = mk(F1_DRTAR, F_NOP, F_NOP, COND_ONE, SEQ_RET, '0);
            default:        word = mk(F_NOP, F_NOP, F_NOP, COND_ONE, SEQ_JMP, ORG_FETCH);
        endcase
    end

endmodule

// File: rtl/ucpu_dec.sv
module ucpu_dec #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]         code,
    output logic [(1 << IN_W)-1:0]  hot
);

    localparam int OUT_N = 1 << IN_W;

    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign hot[i] = (code == IN_W'(i));
    end

endmodule

// File: rtl/ucpu_seq.sv
module ucpu_seq
    import ucpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cond_e              cd,
    input  seq_e               br,
    input  logic [UADDR_W-1:0] ad,
    input  logic               st_ind,
    input  logic               st_sign,
    input  logic               st_zero,
    input  logic [UADDR_W-1:0] map_addr,
    output logic [UADDR_W-1:0] car_q,
    output logic [UADDR_W-1:0] sbr_q
);

    seq_t s_d, s_q;
    logic test;
    logic [UADDR_W-1:0] incr;

    always_comb begin
        case (cd)
            COND_ONE:  test = 1'b1;
            COND_IND:  test = st_ind;
            COND_SIGN: test = st_sign;
            COND_ZERO: test = st_zero;
        endcase
        incr = s_q.car + U1;
        s_d  = s_q;
        case (br)
            SEQ_JMP:  s_d.car = test ? ad : incr;
            SEQ_CALL: begin
                s_d.car = test ? ad : incr;
                if (test) s_d.sbr = incr;
            end
            SEQ_RET:  s_d.car = s_q.sbr;
            SEQ_MAP:  s_d.car = map_addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.car <= ORG_FETCH;
            s_q.sbr <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign car_q = s_q.car;
    assign sbr_q = s_q.sbr;

endmodule

// File: rtl/ucpu_core.sv
module ucpu_core
    import ucpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int OPC_LSB = ADDR_W;
    localparam int IND_BIT = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE_D = 1;
    localparam logic [ADDR_W-1:0] ONE_A = 1;

    typedef struct packed {
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] dr;
        logic [ADDR_W-1:0] ar;
        logic [ADDR_W-1:0] pc;
    } dp_t;

    dp_t dp_d, dp_q;
    uword_t uw;
    logic [UADDR_W-1:0] car_q, sbr_q, map_addr;
    logic [UOP_W-1:0] fcode [3];
    logic [UOP_N-1:0] fhot  [3];
    logic [DATA_W-1:0] ac_q, dr_q;
    logic [ADDR_W-1:0] pc_q, ar_q;

    ucpu_rom i_rom (
        .addr (car_q),
        .word (uw)
    );

    assign fcode[0] = uw.f1;
    assign fcode[1] = uw.f2;
    assign fcode[2] = uw.f3;

    for (genvar k = 0; k < 3; k++) begin : g_fdec
        ucpu_dec #(.IN_W(UOP_W)) i_dec (
            .code (fcode[k]),
            .hot  (fhot[k])
        );
    end

    assign map_addr = {1'b0, dp_q.dr[OPC_LSB +: OPC_W], 2'b00};

    ucpu_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cd       (uw.cd),
        .br       (uw.br),
        .ad       (uw.ad),
        .st_ind   (dp_q.dr[IND_BIT]),
        .st_sign  (dp_q.ac[DATA_W-1]),
        .st_zero  (dp_q.ac == '0),
        .map_addr (map_addr),
        .car_q    (car_q),
        .sbr_q    (sbr_q)
    );

    // every right-hand side reads dp_q, so fields sharing a target see old values
    always_comb begin
        dp_d   = dp_q;
        mem_we = 1'b0;
        unique case (1'b1)
            fhot[0][F_NOP]:    ;
            fhot[0][F1_ADD]:   dp_d.ac = dp_q.ac + dp_q.dr;
            fhot[0][F1_CLR]:   dp_d.ac = '0;
            fhot[0][F1_INC]:   dp_d.ac = dp_q.ac + ONE_D;
            fhot[0][F1_DRTAC]: dp_d.ac = dp_q.dr;
            fhot[0][F1_DRTAR]: dp_d.ar = dp_q.dr[ADDR_W-1:0];
            fhot[0][F1_PCTAR]: dp_d.ar = dp_q.pc;
            fhot[0][F1_WRITE]: mem_we  = 1'b1;
            default:           ;
        endcase
        unique case (1'b1)
            fhot[1][F_NOP]:    ;
            fhot[1][F2_SUB]:   dp_d.ac = dp_q.ac - dp_q.dr;
            fhot[1][F2_OR]:    dp_d.ac = dp_q.ac | dp_q.dr;
            fhot[1][F2_AND]:   dp_d.ac = dp_q.ac & dp_q.dr;
            fhot[1][F2_READ]:  dp_d.dr = mem_rdata;
            fhot[1][F2_ACTDR]: dp_d.dr = dp_q.ac;
            fhot[1][F2_INCDR]: dp_d.dr = dp_q.dr + ONE_D;
            fhot[1][F2_PCTDR]: dp_d.dr[ADDR_W-1:0] = dp_q.pc;
            default:           ;
        endcase
        unique case (1'b1)
            fhot[2][F_NOP]:    ;
            fhot[2][F3_XOR]:   dp_d.ac = dp_q.ac ^ dp_q.dr;
            fhot[2][F3_COM]:   dp_d.ac = ~dp_q.ac;
            fhot[2][F3_SHL]:   dp_d.ac = dp_q.ac << 1;
            fhot[2][F3_SHR]:   dp_d.ac = dp_q.ac >> 1;
            fhot[2][F3_INCPC]: dp_d.pc = dp_q.pc + ONE_A;
            fhot[2][F3_ARTPC]: dp_d.pc = dp_q.ar;
            fhot[2][F3_RSVD]:  ;
            default:           ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr  = dp_q.ar;
    assign mem_wdata = dp_q.dr;
    assign ac_q = dp_q.ac;
    assign dr_q = dp_q.dr;
    assign pc_q = dp_q.pc;
    assign ar_q = dp_q.ar;

endmodule

// File: rtl/ucpu_chk.sv
module ucpu_chk
    import ucpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic [UADDR_W-1:0] car,
    input logic [UADDR_W-1:0] sbr,
    input logic [ADDR_W-1:0]  pc,
    input logic [DATA_W-1:0]  ac,
    input logic [DATA_W-1:0]  dr,
    input logic               we
);

    localparam logic [ADDR_W-1:0] ONE_A = 1;

    a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        (car == ORG_FETCH) |=> (car == ORG_FETCH + U1));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (car == ORG_FETCH + U1) |=> (pc == $past(pc) + ONE_A));

    a_r2_map_target: assert property (@(posedge clk) disable iff (!rst_n)
        (car == ORG_FETCH + U2) |=> (car == {1'b0, $past(dr[ADDR_W +: OPC_W]), 2'b00}));

    a_r10_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
        (car == ORG_INDIR + U1) |=> (car == $past(sbr)));

    a_r5_swap_old_values: assert property (@(posedge clk) disable iff (!rst_n)
        (car == ORG_EXC + U2) |=> (ac == $past(dr) && dr == $past(ac)));

    a_r9_no_write_outside_execute: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !car[UADDR_W-1]);

endmodule

bind ucpu_core ucpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .car   (car_q),
    .sbr   (sbr_q),
    .pc    (pc_q),
    .ac    (ac_q),
    .dr    (dr_q),
    .we    (mem_we)
);

// File: tb/test_ucpu_core.sv
module test_ucpu_core;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    logic [DATA_W-1:0] mem [1 << ADDR_W];

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    bit done = 1'b0;

    logic [ADDR_W-1:0] exp_a [$];
    logic [DATA_W-1:0] exp_d [$];
    string             exp_t [$];

    always #4 clk = ~clk;

    ucpu_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ucpu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    function automatic logic [15:0] ins(input bit ind, input int op, input int a);
        return {ind, 4'(op), 11'(a)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expect_write(input int a, input int d, input string tag);
        exp_a.push_back(ADDR_W'(a));
        exp_d.push_back(DATA_W'(d));
        exp_t.push_back(tag);
    endtask

    // monitor: compares each write cycle against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && mem_we && !done) begin
            wr_seen++;
            if (exp_a.size() == 0) begin
                check(1'b0, "R8 unexpected write addr", int'(mem_addr), 0);
            end else begin
                logic [ADDR_W-1:0] ea;
                logic [DATA_W-1:0] ed;
                string tg;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                tg = exp_t.pop_front();
                check(mem_addr == ea, {tg, " addr"}, int'(mem_addr), int'(ea));
                check(mem_wdata == ed, {tg, " data"}, int'(mem_wdata), int'(ed));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
        // program
        mem[0]  = ins(0, 0, 100);   // ADD 100
        mem[1]  = ins(0, 2, 200);   // STORE 200
        mem[2]  = ins(1, 0, 101);   // ADD @101
        mem[3]  = ins(0, 2, 201);
        mem[4]  = ins(0, 3, 103);   // EXCHANGE 103
        mem[5]  = ins(0, 1, 8);     // BRANCH 8, taken
        mem[6]  = ins(0, 2, 202);   // skipped
        mem[8]  = ins(0, 2, 203);
        mem[9]  = ins(0, 0, 104);   // ADD 0x8001, wraps
        mem[10] = ins(0, 1, 13);    // BRANCH not taken
        mem[11] = ins(0, 2, 204);
        mem[12] = ins(1, 1, 105);   // indirect BRANCH not taken
        mem[13] = ins(1, 3, 106);   // EXCHANGE @106
        mem[14] = ins(0, 2, 205);
        mem[15] = ins(0, 5, 0);     // unused opcode
        mem[16] = ins(0, 2, 206);
        mem[17] = ins(0, 3, 108);   // EXCHANGE 108
        mem[18] = ins(1, 1, 109);   // indirect BRANCH taken
        mem[19] = ins(0, 2, 207);   // skipped
        mem[30] = ins(0, 2, 210);
        mem[31] = ins(0, 1, 31);    // spin
        // data
        mem[100] = 16'd5;
        mem[101] = 16'd102;
        mem[102] = 16'd7;
        mem[103] = 16'h8000;
        mem[104] = 16'h8001;
        mem[106] = 16'd107;
        mem[107] = 16'h1234;
        mem[108] = 16'hF000;
        mem[109] = 16'd30;

        expect_write(200, 16'd5,    "R2 R3 R4 direct add then store");
        expect_write(201, 16'd12,   "R7 R10 indirect add");
        expect_write(103, 16'd12,   "R5 exchange write");
        expect_write(203, 16'h8000, "R6 taken branch");
        expect_write(204, 16'h0001, "R3 add wrap and R6 not taken");
        expect_write(107, 16'h0001, "R5 R7 indirect exchange");
        expect_write(205, 16'h1234, "R5 exchange load");
        expect_write(206, 16'h1234, "R8 unused opcode");
        expect_write(108, 16'h1234, "R5 second exchange");
        expect_write(210, 16'hF000, "R6 R7 indirect taken branch");

        repeat (3) @(negedge clk);
        check(mem_we == 1'b0, "R1 we in reset", int'(mem_we), 0);
        check(mem_addr == '0, "R1 addr in reset", int'(mem_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_we == 1'b0, "R1 we after reset", int'(mem_we), 0);

        repeat (1500) @(negedge clk);
        done = 1'b1;
        check(exp_a.size() == 0, "R4 all writes seen", exp_a.size(), 0);
        check(wr_seen == 10, "R9 write cycles", wr_seen, 10);
        check(mem[202] == '0, "R6 skipped store 202", int'(mem[202]), 0);
        check(mem[207] == '0, "R6 skipped store 207", int'(mem[207]), 0);
        check(mem[100] == 16'd5, "R3 operand kept", int'(mem[100]), 5);
        check(mem[103] == 16'd12, "R5 memory swapped", int'(mem[103]), 12);
        check(mem[107] == 16'd1, "R7 pointer target", int'(mem[107]), 1);
        check(mem[108] == 16'h1234, "R5 final swap", int'(mem[108]), 16'h1234);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule